// File: doc/BRIEF.md
# Delta Modulation Decoder with Smoothing

This block rebuilds a message estimate from a delta-modulated bit stream that carries one bit per sample. Each time the valid strobe is high, the received bit moves a signed running value (the staircase) up or down by a fixed step magnitude. The step magnitude is an input and must match the one the encoder uses. The decoder takes no predicted value from outside. Its only inputs are the bits and the step.

The staircase then feeds a moving-average low-pass stage. This stage sums the most recent 2^`AVG_LOG2` staircase values and divides by the window with an arithmetic right shift. The block presents the staircase value, the smoothed value and an output strobe together, two clock cycles after each accepted input bit. Reset zeroes the staircase and the whole averaging window, which is the same state an encoder starts from. An encoder and decoder that share the step and the reset therefore hold equal staircase values sample for sample.

Top module: `dm_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `stair_out` and `smooth_out` are 0 until the first accepted bit.
- R2: An accepted bit of value 1 makes the next staircase value equal the previous staircase value plus `step`.
- R3: An accepted bit of value 0 makes the next staircase value equal the previous staircase value minus `step`.
- R4: The staircase saturates. A result above 2^(SAMPLE_W-1)-1 becomes 2^(SAMPLE_W-1)-1, and a result below -2^(SAMPLE_W-1) becomes -2^(SAMPLE_W-1).
- R5: A cycle with `in_valid` low changes neither the staircase nor the window and produces no output strobe. The outputs hold their last values.
- R6: `smooth_out` equals the sum of the last 2^AVG_LOG2 staircase values, arithmetically shifted right by AVG_LOG2. Before that many samples have arrived, the missing entries count as zero.
- R7: `out_valid` is high for exactly one cycle, two clock cycles after each cycle with `in_valid` high. Back-to-back inputs give back-to-back outputs in the same order.
- R8: A `step` of 0 leaves the staircase unchanged for either bit value, and the window still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Received bit: 1 steps up, 0 steps down |
| step | input | STEP_W | Unsigned step magnitude |
| out_valid | output | 1 | Strobe: new staircase and smoothed values |
| stair_out | output | SAMPLE_W | Signed staircase value |
| smooth_out | output | SAMPLE_W | Signed moving-average value |

## Verification
A wrong staircase register shows up at the next output strobe as a `stair_out` value that differs from the expected running value. Because every later sample builds on that register, the error then stays in the stream. A corrupted window entry or running sum first shows as a wrong `smooth_out`. It stays wrong for up to 2^AVG_LOG2 samples, or forever if the running sum is off. The saturation runs show whether clamping happens at the exact range limit. The idle gaps show whether a cycle without a valid strobe leaks into the state.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam logic BIT_UP = 1'b1;
  localparam int   LAT_CYCLES = 2;
endpackage

// File: rtl/dm_step_acc.sv
module dm_step_acc #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       up,
  input  logic [STEP_W-1:0]          step,
  output logic signed [SAMPLE_W-1:0] acc_o,
  output logic                       vld_o
);
  import dm_pkg::*;
  localparam int EXT_W = SAMPLE_W + 1;
  localparam logic signed [EXT_W-1:0] HI = EXT_W'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [EXT_W-1:0] LO = -HI - EXT_W'(1);

  logic signed [SAMPLE_W-1:0] acc_q, acc_d;
  logic                       vld_q;
  logic signed [EXT_W-1:0]    ext_acc, ext_step, raw;

  always_comb begin
    ext_acc  = {acc_q[SAMPLE_W-1], acc_q};
    ext_step = EXT_W'(step);
    raw      = (up == BIT_UP) ? ext_acc + ext_step : ext_acc - ext_step;
    if (raw > HI)      acc_d = HI[SAMPLE_W-1:0];
    else if (raw < LO) acc_d = LO[SAMPLE_W-1:0];
    else               acc_d = raw[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/dm_box_filter.sv
module dm_box_filter #(
  parameter int SAMPLE_W = 12,
  parameter int AVG_LOG2 = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] newest_o,
  output logic signed [SAMPLE_W-1:0] avg_o,
  output logic                       vld_o
);
  localparam int WIN   = 1 << AVG_LOG2;
  localparam int SUM_W = SAMPLE_W + AVG_LOG2;

  logic signed [SAMPLE_W-1:0] tap_q [WIN];
  logic signed [SUM_W-1:0]    sum_q, sum_d, avg_full;
  logic                       vld_q;

  always_comb begin
    sum_d = sum_q + SUM_W'(din) - SUM_W'(tap_q[WIN-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q[0] <= '0;
      sum_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) begin
        tap_q[0] <= din;
        sum_q    <= sum_d;
      end
    end
  end

  for (genvar g = 1; g < WIN; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tap_q[g] <= '0;
      else if (en) tap_q[g] <= tap_q[g-1];
    end
  end

  assign avg_full = sum_q >>> AVG_LOG2;
  assign avg_o    = avg_full[SAMPLE_W-1:0];
  assign newest_o = tap_q[0];
  assign vld_o    = vld_q;
endmodule

// File: rtl/dm_decoder.sv
module dm_decoder #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_W   = 8,
  parameter int AVG_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_bit,
  input  logic [STEP_W-1:0]   step,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] stair_out,
  output logic [SAMPLE_W-1:0] smooth_out
);
  logic                       rst_meta_q, rst_sync_q;
  logic signed [SAMPLE_W-1:0] acc_val, newest, avg;
  logic                       acc_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dm_step_acc #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_q), .en(in_valid), .up(in_bit), .step(step),
    .acc_o(acc_val), .vld_o(acc_vld)
  );

  dm_box_filter #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_flt (
    .clk(clk), .rst_n(rst_sync_q), .en(acc_vld), .din(acc_val),
    .newest_o(newest), .avg_o(avg), .vld_o(out_valid)
  );

  assign stair_out  = newest;
  assign smooth_out = avg;
endmodule

// File: rtl/dm_decoder_chk.sv
module dm_decoder_chk #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_bit,
  input logic [STEP_W-1:0]   step,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] stair_out,
  input logic [SAMPLE_W-1:0] smooth_out
);
  logic signed [SAMPLE_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= '0;
    else if (out_valid) last_q <= $signed(stair_out);
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_up_moves_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_bit, 2)) |-> ($signed(stair_out) >= last_q));

  p_down_moves_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_bit, 2)) |-> ($signed(stair_out) <= last_q));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(stair_out) && $stable(smooth_out)));

  p_strobe_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
endmodule

bind dm_decoder dm_decoder_chk #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_q), .in_valid(in_valid), .in_bit(in_bit), .step(step),
  .out_valid(out_valid), .stair_out(stair_out), .smooth_out(smooth_out)
);

// File: tb/dm_decoder_test.sv
module dm_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int PW = 8;
  localparam int AL = 2;
  localparam int WIN = 1 << AL;
  localparam int HI = (1 << (SW-1)) - 1;
  localparam int LO = -(1 << (SW-1));

  logic clk = 1'b0;
  logic rst_n, in_valid, in_bit;
  logic [PW-1:0] step;
  logic out_valid;
  logic [SW-1:0] stair_out, smooth_out;

  int tests = 0, fails = 0;
  int m_acc = 0;
  int m_tap [WIN];
  int exp_st [$];
  int exp_sm [$];
  string exp_tag [$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_decoder #(.SAMPLE_W(SW), .STEP_W(PW), .AVG_LOG2(AL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .step(step),
    .out_valid(out_valid), .stair_out(stair_out), .smooth_out(smooth_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit b, input int s, input string tag);
    int nxt, sum;
    nxt = b ? m_acc + s : m_acc - s;
    if (nxt > HI) nxt = HI;
    if (nxt < LO) nxt = LO;
    m_acc = nxt;
    for (int i = WIN-1; i > 0; i--) m_tap[i] = m_tap[i-1];
    m_tap[0] = nxt;
    sum = 0;
    for (int i = 0; i < WIN; i++) sum += m_tap[i];
    exp_st.push_back(nxt);
    exp_sm.push_back(sum >>> AL);
    exp_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; step = PW'(s);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic burst(input bit b, input int s, input int n, input string tag);
    int nxt, sum;
    for (int k = 0; k < n; k++) begin
      nxt = b ? m_acc + s : m_acc - s;
      if (nxt > HI) nxt = HI;
      if (nxt < LO) nxt = LO;
      m_acc = nxt;
      for (int i = WIN-1; i > 0; i--) m_tap[i] = m_tap[i-1];
      m_tap[0] = nxt;
      sum = 0;
      for (int i = 0; i < WIN; i++) sum += m_tap[i];
      exp_st.push_back(nxt);
      exp_sm.push_back(sum >>> AL);
      exp_tag.push_back(tag);
      @(negedge clk);
      in_valid = 1'b1; in_bit = b; step = PW'(s);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops expected items on each output strobe (R7 ordering, R5 no stray strobe)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_st.size() == 0) begin
        check("R5 stray out_valid", 1, 0);
      end else begin
        string t;
        t = exp_tag.pop_front();
        check({t, " R6 smooth"}, $signed(smooth_out), exp_sm.pop_front());
        check({t, " stair"}, $signed(stair_out), exp_st.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < WIN; i++) m_tap[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; step = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 stair in reset", stair_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 smooth after reset", smooth_out, 0);

    send(1, 5, "R2 up");
    send(1, 5, "R2 up");
    send(0, 3, "R3 down");
    repeat (3) @(negedge clk);
    burst(0, 7, 6, "R3 down burst");
    burst(1, 20, 3, "R2 up burst");
    repeat (4) @(negedge clk);
    // R5: idle cycles keep outputs
    check("R5 stair held", $signed(stair_out), m_acc);
    repeat (5) @(negedge clk);
    check("R5 stair held later", $signed(stair_out), m_acc);
    for (int k = 0; k < 10; k++) send(k[0], 9, "R2 R3 alternate");
    burst(1, 0, 3, "R8 zero step up");
    burst(0, 0, 3, "R8 zero step down");
    burst(1, 255, 12, "R4 saturate high");
    repeat (3) @(negedge clk);
    check("R4 high clamp", $signed(stair_out), HI);
    burst(0, 255, 20, "R4 saturate low");
    repeat (3) @(negedge clk);
    check("R4 low clamp", $signed(stair_out), LO);
    burst(1, 1, 5, "R2 leave low rail");
    repeat (4) @(negedge clk);
    check("R7 all strobes seen", exp_st.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule